// File: doc/BRIEF.md
# Paged One-Time-Programmable Storage Register Interface

This block puts a small register file in front of a page-organised one-time-programmable store. In this design the store is an ordinary on-chip array. A page is 128 bits, held as four 32-bit words. Software first fills four data registers and a 16-bit byte-enable mask. It then writes the control register with a page number and command bits. The block then moves one page between the data registers and the array, touching only the bytes whose enable bit is 1. At the end it raises a sticky done flag, which drives the interrupt output.

The transfer is run by a four-state sequencer. `SEQ_IDLE` waits for a control write. From there it goes to `SEQ_PROGRAM` if the write command is set, otherwise to `SEQ_FETCH` if the read command is set, otherwise to `SEQ_FINISH`. `SEQ_PROGRAM` stores the masked data registers into the page. It then moves on to `SEQ_FETCH` when the read command is also set, otherwise to `SEQ_FINISH`. `SEQ_FETCH` loads the masked page into the data registers and always moves on to `SEQ_FINISH`. `SEQ_FINISH` sets the done flag and always returns to `SEQ_IDLE`.

The register bus is a single-cycle strobe interface. It carries separate read and write strobes, an 8-bit byte offset, a size bit (0 = 16-bit access, 1 = 32-bit access) and write data. Read data and the error pulse are registered and appear one cycle after the strobe.

Top module: `otp_regblk`

## Requirements
- R1: After reset, control reads 0x0000, byte-enable reads 0xFFFF, status reads 0x0000, timing reads 0x00001485, all data registers read 0, and `done_irq` is low.
- R2: The register map is as follows. These are 16-bit registers: control at 0x00, byte-enable at 0x04, status at 0x08. These are 32-bit registers: timing at 0x0C, data words 0 to 3 at 0x80, 0x84, 0x88, 0x8C. An access to any other offset, or with the wrong size bit, returns 0 on read and changes nothing on write. It also raises `bus_err` in the following cycle.
- R3: A control write stores `wdata[15:0] & 0x39FF`, and reading control returns that value. The page number is bits [8:0].
- R4: When control bit 11 (write command) is set, the data registers are stored into the addressed page. Page byte i comes from data word i/4, bits [8*(i%4)+7 : 8*(i%4)]. Only bytes whose byte-enable bit i is 1 change.
- R5: When control bit 12 (read command) is set, the addressed page is copied into the data registers using the same byte layout. Data bytes whose enable bit is 0 keep their old values.
- R6: When both command bits are set, the page is written first and then read back, so the data registers end up holding the updated page.
- R7: Status bit 0 (done) goes high on the clock edge that is 1 + W + R edges after the control write edge. W and R are the write and read command bits (each 0 or 1). Every control write sets done, including one with no command bits.
- R8: Status is write-one-to-clear. A 16-bit write to status with bit 0 set clears done; a write with bit 0 clear leaves it unchanged. Status bits 15:1 always read 0.
- R9: `done_irq` equals the done bit in every cycle.
- R10: While a transfer is in progress (sequencer not idle), bus writes to any register are ignored and raise `bus_err` in the following cycle. Reads are still served.
- R11: Timing and the four data registers are plain 32-bit read/write storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wide | input | 1 | Access size: 0 = 16-bit, 1 = 32-bit |
| bus_wdata | input | 32 | Write data (16-bit registers use bits 15:0) |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle pulse after an illegal or refused access |
| done_irq | output | 1 | High while the done status bit is set |

## Verification
Read data and the error pulse follow their strobe by exactly one edge. The done flag rises 1 + W + R edges after the control write edge, so a plain control write finishes in one edge and a combined write-and-read in three. The bench keeps a behavioural model that applies each access on the same edge the design sees it. It counts those edges down to the edge where done is due. On every falling edge it compares `done_irq`, `bus_err` and, after any read, `bus_rdata` with the model. The cycle-exact timing therefore gets checked on every cycle, not only at chosen points. Page contents are checked by reading the data registers back only once the sequencer has returned to idle.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int unsigned BUS_AW     = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PAGE_WORDS = 4;
    localparam int unsigned PAGE_BYTES = PAGE_WORDS * (WORD_W / 8);
    localparam int unsigned PAGE_W     = PAGE_BYTES * 8;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_BEN  = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_STAT = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_TIME = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_DATA = 8'h80;

    localparam logic [15:0] CTRL_KEEP  = 16'h39FF;
    localparam int unsigned CMD_WR_BIT = 11;
    localparam int unsigned CMD_RD_BIT = 12;
    localparam logic [15:0] BEN_RST    = 16'hFFFF;
    localparam logic [31:0] TIME_RST   = 32'h0000_1485;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PROGRAM,
        SEQ_FETCH,
        SEQ_FINISH
    } seq_state_t;

    typedef struct packed {
        logic                  ctrl;
        logic                  ben;
        logic                  stat;
        logic                  tim;
        logic [PAGE_WORDS-1:0] data;
    } reg_sel_t;
endpackage

// File: rtl/otp_decode.sv
module otp_decode
    import otp_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    input  logic              wide,
    input  logic              access,
    output reg_sel_t          sel,
    output logic              bad
);
    always_comb begin
        sel = '0;
        case (addr)
            OFS_CTRL: sel.ctrl = !wide;
            OFS_BEN:  sel.ben  = !wide;
            OFS_STAT: sel.stat = !wide;
            OFS_TIME: sel.tim  = wide;
            default:  ;
        endcase
        for (int w = 0; w < PAGE_WORDS; w++) begin
            if (addr == OFS_DATA + 8'(4 * w)) sel.data[w] = wide;
        end
        bad = access && (sel == '0);
    end
endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmd_wr,
    input  logic       cmd_rd,
    input  logic       keep_rd,
    output seq_state_t state,
    output logic       prog_en,
    output logic       fetch_en,
    output logic       finish,
    output logic       busy
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:
                if (start) state_d = cmd_wr ? SEQ_PROGRAM : (cmd_rd ? SEQ_FETCH : SEQ_FINISH);
            SEQ_PROGRAM: state_d = keep_rd ? SEQ_FETCH : SEQ_FINISH;
            SEQ_FETCH:   state_d = SEQ_FINISH;
            SEQ_FINISH:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state    = state_q;
        prog_en  = (state_q == SEQ_PROGRAM);
        fetch_en = (state_q == SEQ_FETCH);
        finish   = (state_q == SEQ_FINISH);
        busy     = (state_q != SEQ_IDLE);
    end

    // R6
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PROGRAM && keep_rd) |=> (state_q == SEQ_FETCH));
    // R7
    finish_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_FINISH) |=> (state_q == SEQ_IDLE));
    // R7
    fetch_to_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_FETCH) |=> (state_q == SEQ_FINISH));
endmodule

// File: rtl/otp_page_array.sv
module otp_page_array
    import otp_pkg::*;
#(
    parameter int unsigned PAGES = 512,
    localparam int unsigned AW   = $clog2(PAGES)
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [AW-1:0]         page,
    input  logic [PAGE_W-1:0]     wdata,
    input  logic [PAGE_BYTES-1:0] wmask,
    output logic [PAGE_W-1:0]     rdata
);
    logic [PAGE_W-1:0] mem [PAGES];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < PAGE_BYTES; b++) begin
                if (wmask[b]) mem[page][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem[page];
endmodule

// File: rtl/otp_regblk.sv
module otp_regblk
    import otp_pkg::*;
#(
    parameter int unsigned PAGES = 512,
    localparam int unsigned PAGE_AW = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wide,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              done_irq
);
    reg_sel_t          sel;
    logic              bad, busy, prog_en, fetch_en, finish, wr_ok;
    seq_state_t        state;
    logic [15:0]       ctrl_q, ben_q;
    logic              done_q;
    logic [31:0]       time_q, rd_mux, rdata_q;
    logic              err_q;
    logic [PAGE_W-1:0] page_flat, arr_rd;

    otp_decode u_dec (
        .addr(bus_addr), .wide(bus_wide), .access(bus_rd | bus_wr),
        .sel(sel), .bad(bad)
    );

    assign wr_ok = bus_wr && !busy;

    otp_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(wr_ok && sel.ctrl),
        .cmd_wr(bus_wdata[CMD_WR_BIT]), .cmd_rd(bus_wdata[CMD_RD_BIT]),
        .keep_rd(ctrl_q[CMD_RD_BIT]),
        .state(state), .prog_en(prog_en), .fetch_en(fetch_en),
        .finish(finish), .busy(busy)
    );

    otp_page_array #(.PAGES(PAGES)) u_arr (
        .clk(clk), .we(prog_en), .page(ctrl_q[PAGE_AW-1:0]),
        .wdata(page_flat), .wmask(ben_q), .rdata(arr_rd)
    );

    for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (fetch_en) begin
                for (int b = 0; b < WORD_W / 8; b++) begin
                    if (ben_q[4*w + b]) word_q[8*b +: 8] <= arr_rd[WORD_W*w + 8*b +: 8];
                end
            end else if (wr_ok && sel.data[w]) begin
                word_q <= bus_wdata;
            end
        end
        assign page_flat[WORD_W*w +: WORD_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ben_q  <= BEN_RST;
            time_q <= TIME_RST;
            done_q <= 1'b0;
        end else begin
            if (wr_ok && sel.ctrl) ctrl_q <= bus_wdata[15:0] & CTRL_KEEP;
            if (wr_ok && sel.ben)  ben_q  <= bus_wdata[15:0];
            if (wr_ok && sel.tim)  time_q <= bus_wdata;
            if (finish)                                done_q <= 1'b1;
            else if (wr_ok && sel.stat && bus_wdata[0]) done_q <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel.ctrl) rd_mux = {16'h0, ctrl_q};
        if (sel.ben)  rd_mux = {16'h0, ben_q};
        if (sel.stat) rd_mux = {31'h0, done_q};
        if (sel.tim)  rd_mux = time_q;
        for (int w = 0; w < PAGE_WORDS; w++) begin
            if (sel.data[w]) rd_mux = page_flat[WORD_W*w +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (bus_rd) rdata_q <= rd_mux;
            err_q <= bad || (bus_wr && busy);
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign done_irq  = done_q;

    // R2
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bad) |=> (bus_rdata == 32'h0));
    // R7
    done_from_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state) == SEQ_FINISH));
    // R8
    stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && bus_wr && !bus_wide && bus_addr == OFS_STAT && bus_wdata[0])
        |=> !done_q);
    // R10
    busy_ben_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ben_q) && $stable(time_q)));
    // R9
    irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_irq) |-> ($past(bus_wr) && $past(bus_addr) == OFS_STAT));
endmodule

// File: tb/sim_otp_regblk.sv
`timescale 1ns/1ps
module sim_otp_regblk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, done_irq;

    otp_regblk u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .done_irq(done_irq)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit run = 0, ended = 0;

    // behavioural reference state
    logic [127:0] m_mem [int];
    logic [15:0]  m_ctrl, m_ben;
    logic [31:0]  m_time;
    logic [31:0]  m_data [4];
    logic         m_done;
    int           pend;
    logic [31:0]  e_rdata;
    logic         e_err, e_rchk;
    string        e_tag, cur_tag;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input logic [7:0] a, input logic wide);
        case (a)
            8'h00, 8'h04, 8'h08:                      return !wide;
            8'h0C, 8'h80, 8'h84, 8'h88, 8'h8C:        return wide;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h00: return {16'h0, m_ctrl};
            8'h04: return {16'h0, m_ben};
            8'h08: return {31'h0, m_done};
            8'h0C: return m_time;
            default: return m_data[(a - 8'h80) >> 2];
        endcase
    endfunction

    task automatic mwrite(input logic [7:0] a, input logic [31:0] d);
        logic [127:0] pg_val;
        int pg;
        case (a)
            8'h00: begin
                m_ctrl = d[15:0] & 16'h39FF;
                pg = int'(d[8:0]);
                pg_val = m_mem.exists(pg) ? m_mem[pg] : 128'h0;
                if (d[11]) begin
                    for (int b = 0; b < 16; b++)
                        if (m_ben[b]) pg_val[8*b +: 8] = m_data[b/4][8*(b%4) +: 8];
                    m_mem[pg] = pg_val;
                end
                if (d[12]) begin
                    for (int b = 0; b < 16; b++)
                        if (m_ben[b]) m_data[b/4][8*(b%4) +: 8] = pg_val[8*b +: 8];
                end
                pend = 1 + int'(d[11]) + int'(d[12]);
            end
            8'h04: m_ben = d[15:0];
            8'h08: if (d[0]) m_done = 1'b0;
            8'h0C: m_time = d;
            default: m_data[(a - 8'h80) >> 2] = d;
        endcase
    endtask

    always @(posedge clk) begin
        bit busy, ok;
        if (!rst_n) begin
            m_ctrl = 16'h0; m_ben = 16'hFFFF; m_time = 32'h1485; m_done = 1'b0;
            for (int i = 0; i < 4; i++) m_data[i] = 32'h0;
            pend = 0; e_err = 1'b0; e_rchk = 1'b0;
        end else begin
            busy = (pend > 0);
            ok = legal(bus_addr, bus_wide);
            e_err = 1'b0; e_rchk = 1'b0;
            if (bus_rd) begin
                e_rchk = 1'b1; e_tag = cur_tag;
                e_rdata = ok ? mread(bus_addr) : 32'h0;
                if (!ok) e_err = 1'b1;
            end
            if (pend > 0) begin
                pend--;
                if (pend == 0) m_done = 1'b1;
            end
            if (bus_wr) begin
                if (!ok || busy) e_err = 1'b1;
                else mwrite(bus_addr, bus_wdata);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run && !ended) begin
            check("R7 R9 done_irq", {31'h0, done_irq}, {31'h0, m_done});
            check("R2 R10 bus_err", {31'h0, bus_err}, {31'h0, e_err});
            if (e_rchk) check(e_tag, bus_rdata, e_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic wide, input logic [31:0] d);
        bus_addr = a; bus_wide = wide; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic wide, input string tag);
        cur_tag = tag; bus_addr = a; bus_wide = wide; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_page(input string tag);
        for (int w = 0; w < 4; w++) rd(8'h80 + 8'(4*w), 1'b1, tag);
    endtask

    task automatic fill(input logic [31:0] base);
        for (int w = 0; w < 4; w++) wr(8'h80 + 8'(4*w), 1'b1, base + 32'(w * 32'h0404_0404));
    endtask

    task automatic finish_run;
        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; run = 1;
        check("R1 done_irq reset", {31'h0, done_irq}, 32'h0);
        rd(8'h00, 1'b0, "R1 ctrl reset");
        rd(8'h04, 1'b0, "R1 ben reset");
        rd(8'h08, 1'b0, "R1 status reset");
        rd(8'h0C, 1'b1, "R1 timing reset");
        rd_page("R1 data reset");

        wr(8'h0C, 1'b1, 32'hDEAD_BEEF);
        rd(8'h0C, 1'b1, "R11 timing rw");
        fill(32'h1357_9BDF);
        rd_page("R11 data rw");

        rd(8'h10, 1'b1, "R2 undefined offset read");
        rd(8'h04, 1'b1, "R2 wrong size read");
        wr(8'h0C, 1'b0, 32'h0000_1234);
        rd(8'h0C, 1'b1, "R2 wrong size write ignored");
        wr(8'h44, 1'b1, 32'hFFFF_FFFF);
        rd_page("R2 undefined write ignored");

        wr(8'h00, 1'b0, 32'h0000_FFFF);
        idle(5);
        rd(8'h00, 1'b0, "R3 ctrl mask");
        rd_page("R6 page 0x1FF roundtrip");
        wr(8'h08, 1'b0, 32'h1);

        fill(32'h0302_0100);
        wr(8'h00, 1'b0, 32'h0805);
        idle(4);
        fill(32'h0);
        wr(8'h00, 1'b0, 32'h1005);
        idle(4);
        rd_page("R4 R5 page 5 full mask");

        wr(8'h04, 1'b0, 32'h00F0);
        for (int w = 0; w < 4; w++) wr(8'h80 + 8'(4*w), 1'b1, 32'hFFFF_FFFF);
        wr(8'h00, 1'b0, 32'h0805);
        idle(4);
        wr(8'h04, 1'b0, 32'hFFFF);
        fill(32'h0);
        wr(8'h00, 1'b0, 32'h1005);
        idle(4);
        rd_page("R4 partial write mask");

        wr(8'h04, 1'b0, 32'h0F0F);
        for (int w = 0; w < 4; w++) wr(8'h80 + 8'(4*w), 1'b1, 32'hAAAA_AAAA);
        wr(8'h00, 1'b0, 32'h1005);
        idle(4);
        rd_page("R5 partial read mask");

        wr(8'h04, 1'b0, 32'hFFFF);
        fill(32'h5060_7080);
        wr(8'h00, 1'b0, 32'h1807);
        idle(5);
        rd_page("R6 write then read");
        fill(32'h0);
        wr(8'h00, 1'b0, 32'h1007);
        idle(4);
        rd_page("R6 page 7 stored");

        wr(8'h08, 1'b0, 32'h0);
        rd(8'h08, 1'b0, "R8 write zero keeps done");
        wr(8'h08, 1'b0, 32'h1);
        rd(8'h08, 1'b0, "R8 write one clears done");

        wr(8'h00, 1'b0, 32'h0000);
        check("R7 no-command done pending", {31'h0, done_irq}, 32'h0);
        @(negedge clk);
        check("R7 no-command done after one edge", {31'h0, done_irq}, 32'h1);
        wr(8'h08, 1'b0, 32'h1);

        wr(8'h00, 1'b0, 32'h0805);
        wr(8'h80, 1'b1, 32'h5555_5555);
        wr(8'h04, 1'b0, 32'h0000);
        idle(4);
        rd(8'h80, 1'b1, "R10 busy write ignored");
        rd(8'h04, 1'b0, "R10 busy ben write ignored");
        idle(2);
        finish_run();
    end
endmodule